// File: doc/BRIEF.md
# Adaptive Dead-Time Generator

This block drives the two gate enables of a half-bridge resonant stage from a single phase command and inserts a dead time between one switch turning off and the other turning on. The length of that gap is not fixed. On the high-side-off to low-side-on edge, the block watches a digitized slew-rate flag taken from the switch node. That flag is high while the node is moving faster than a fixed threshold. When the flag has risen and then fallen again, the node has finished its swing, and the low-side switch is turned on without further delay.

The gap measured on that edge is held in a register. The same gap is then applied to the low-side-off to high-side-on edge, which is never measured. If no rise-then-fall of the flag is seen, the block waits the full maximum dead time. A parameter sets a minimum dead time that is always respected. The flag is asynchronous to the block clock and passes through a two-stage synchronizer.

Top module: `adt_gen`

## Requirements
- R1: `hs_en` and `ls_en` are never both high in the same cycle.
- R2: While `rst` is high, both enables are low and `dt_count` equals DT_MAX. The first edge after reset starts a low-to-high gap timed by `dt_count`. With `phase_cmd` high, `hs_en` therefore rises after DT_MAX cycles with both enables low.
- R3: Edge 0 is the clock edge at which `hs_en` falls after `phase_cmd` goes low. Suppose `slew_flag` is driven high before edge a (a >= 0) and low before edge b (b > a). Then `ls_en` rises at edge b+2, so the gap is b+2 cycles, when that value lies between DT_MIN and DT_MAX.
- R4: If `slew_flag` stays low for the whole gap, `ls_en` rises after exactly DT_MAX cycles with both enables low.
- R5: `ls_en` never rises before DT_MIN cycles with both enables low. A slew-done seen earlier turns `ls_en` on at exactly DT_MIN.
- R6: A slew-done that would arrive after DT_MAX has no effect, and the gap is DT_MAX.
- R7: From the cycle in which `ls_en` rises, `dt_count` shows the number of both-low cycles of that high-to-low gap.
- R8: After `phase_cmd` goes high in the low-side phase, `hs_en` rises after exactly `dt_count` both-low cycles. Activity on `slew_flag` during that gap has no effect on its length.
- R9: A reset asserted in the middle of a gap forces both enables low and returns `dt_count` to DT_MAX on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_cmd | input | 1 | 1 requests the high-side switch, 0 the low-side switch |
| slew_flag | input | 1 | Asynchronous flag, high while the switch-node slew exceeds the threshold |
| hs_en | output | 1 | Registered high-side gate enable |
| ls_en | output | 1 | Registered low-side gate enable |
| dt_count | output | CW | Dead time held for the low-to-high gap, in cycles |

## Verification
The bench builds the block with DT_MIN = 5 and DT_MAX = 12. With these values, the fastest detectable slew (three cycles, set by the synchronizer and the detection cycle) lands below the floor, so the clamp at DT_MIN is reachable. A slew that finishes late falls past the ceiling within a short window. The vector table places the rise and fall of the flag at chosen edges and compares each measured gap with the rule in R3 to R6. It then replays every result on the opposite edge to confirm the copy.

// File: rtl/adt_pkg.sv
package adt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_HS    = 3'd1,
    ST_DT_HL = 3'd2,
    ST_LS    = 3'd3,
    ST_DT_LH = 3'd4
  } adt_state_e;
endpackage

// File: rtl/adt_sync.sv
module adt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= 1'b0;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= 1'b0;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/adt_slew_det.sv
module adt_slew_det (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic s,
  output logic done
);
  logic seen_q;

  // seen_q remembers that the flag went high inside the current window
  always_ff @(posedge clk) begin
    if (rst || !en) seen_q <= 1'b0;
    else if (s)     seen_q <= 1'b1;
  end

  // slew is complete once the flag is back low after having been high
  assign done = en && seen_q && !s;

  // R3
  done_needs_rise_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(en));
endmodule

// File: rtl/adt_dt_ctrl.sv
module adt_dt_ctrl
  import adt_pkg::*;
#(
  parameter int DT_MIN = 4,
  parameter int DT_MAX = 32,
  parameter int CW     = $clog2(DT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          phase_cmd,
  input  logic          slew_done,
  output logic          meas_en,
  output logic          hs_en,
  output logic          ls_en,
  output logic [CW-1:0] dt_count
);
  localparam logic [CW-1:0] MIN_C = CW'(DT_MIN);
  localparam logic [CW-1:0] MAX_C = CW'(DT_MAX);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  adt_state_e    state, state_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [CW-1:0] dt_q;
  logic          hs_q, ls_q;
  logic          hit_min, hit_max, hit_copy;
  logic          in_gap, in_gap_n;

  assign hit_min  = (cnt >= MIN_C);
  assign hit_max  = (cnt >= MAX_C);
  assign hit_copy = (cnt >= dt_q);
  assign in_gap   = (state == ST_DT_HL) || (state == ST_DT_LH);
  assign in_gap_n = (state_n == ST_DT_HL) || (state_n == ST_DT_LH);

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE:  state_n = phase_cmd ? ST_DT_LH : ST_DT_HL;
      ST_HS:    if (!phase_cmd) state_n = ST_DT_HL;
      ST_DT_HL: if (hit_max || (hit_min && slew_done)) state_n = ST_LS;
      ST_LS:    if (phase_cmd) state_n = ST_DT_LH;
      ST_DT_LH: if (hit_copy) state_n = ST_HS;
      default:  state_n = ST_IDLE;
    endcase
  end

  always_comb begin
    if (!in_gap_n)            cnt_n = '0;
    else if (!in_gap)         cnt_n = ONE_C;
    else if (cnt >= MAX_C)    cnt_n = MAX_C;
    else                      cnt_n = cnt + ONE_C;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      dt_q  <= MAX_C;
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
      hs_q  <= (state_n == ST_HS);
      ls_q  <= (state_n == ST_LS);
      if (state == ST_DT_HL && state_n == ST_LS)
        dt_q <= hit_max ? MAX_C : cnt;
    end
  end

  assign meas_en  = (state == ST_DT_HL);
  assign hs_en    = hs_q;
  assign ls_en    = ls_q;
  assign dt_count = dt_q;

  // R5
  dt_floor_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ls_q) |-> (dt_q >= MIN_C));

  // R6
  dt_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DT_HL && cnt == MAX_C) |=> ls_q);

  // R8
  copy_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HS && $past(state) == ST_DT_LH) |-> ($past(cnt) == dt_q));
endmodule

// File: rtl/adt_gen.sv
module adt_gen #(
  parameter int DT_MIN    = 4,
  parameter int DT_MAX    = 32,
  parameter int SYNC_DEPTH = 2,
  parameter int CW        = $clog2(DT_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          phase_cmd,
  input  logic          slew_flag,
  output logic          hs_en,
  output logic          ls_en,
  output logic [CW-1:0] dt_count
);
  logic slew_s;
  logic meas_en;
  logic slew_done;

  adt_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (slew_flag),
    .q   (slew_s)
  );

  adt_slew_det u_det (
    .clk  (clk),
    .rst  (rst),
    .en   (meas_en),
    .s    (slew_s),
    .done (slew_done)
  );

  adt_dt_ctrl #(
    .DT_MIN (DT_MIN),
    .DT_MAX (DT_MAX),
    .CW     (CW)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .phase_cmd (phase_cmd),
    .slew_done (slew_done),
    .meas_en   (meas_en),
    .hs_en     (hs_en),
    .ls_en     (ls_en),
    .dt_count  (dt_count)
  );

  // R1
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(hs_en && ls_en));

  // R2
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!hs_en && !ls_en && dt_count == CW'(DT_MAX)));
endmodule

// File: tb/sim_adt_gen.sv
module sim_adt_gen;
  localparam int CLK_PERIOD = 10;
  localparam int DT_MIN = 5;
  localparam int DT_MAX = 12;
  localparam int CW = $clog2(DT_MAX + 1);
  localparam int NVEC = 7;
  // columns: rise edge a, fall edge b, pulse present, expected gap
  localparam int VEC [NVEC][4] = '{
    '{0, 1,  1, 5},
    '{1, 4,  1, 6},
    '{2, 7,  1, 9},
    '{0, 0,  0, 12},
    '{3, 10, 1, 12},
    '{4, 15, 1, 12},
    '{2, 8,  1, 10}
  };

  logic clk = 1'b0;
  logic rst, phase_cmd, slew_flag;
  logic hs_en, ls_en;
  logic [CW-1:0] dt_count;
  int n_chk = 0, n_bad = 0, overlap = 0;

  adt_gen #(.DT_MIN(DT_MIN), .DT_MAX(DT_MAX)) u0 (
    .clk(clk), .rst(rst), .phase_cmd(phase_cmd), .slew_flag(slew_flag),
    .hs_en(hs_en), .ls_en(ls_en), .dt_count(dt_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (hs_en && ls_en) overlap++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string tag_of(input int v, input int exp);
    if (v == 0)           return "R4";
    else if (exp == DT_MIN) return "R5";
    else if (exp == DT_MAX) return "R6";
    else                  return "R3";
  endfunction

  // high-to-low gap; edge 0 is the first posedge after phase_cmd drops
  task automatic run_hl(input int a, input int b, input int v, output int n);
    n = 0;
    phase_cmd = 1'b0;
    if (v != 0 && a == 0) slew_flag = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (!hs_en && !ls_en) n++;
      if (ls_en) break;
      if (v != 0 && k + 1 == a) slew_flag = 1'b1;
      if (v != 0 && k + 1 == b) slew_flag = 1'b0;
    end
    slew_flag = 1'b0;
  endtask

  task automatic run_lh(input bit wiggle, output int n);
    n = 0;
    phase_cmd = 1'b1;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (!hs_en && !ls_en) n++;
      if (hs_en) break;
      if (wiggle) slew_flag = ~slew_flag;
    end
    slew_flag = 1'b0;
  endtask

  initial begin
    int n;
    rst = 1'b1; phase_cmd = 1'b1; slew_flag = 1'b0;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(!hs_en && !ls_en, "R2 enables in reset", {hs_en, ls_en}, 0);
    chk(dt_count == DT_MAX, "R2 dt_count in reset", dt_count, DT_MAX);
    rst = 1'b0;
    run_lh(1'b0, n);
    chk(n == DT_MAX, "R2 first high-side gap", n, DT_MAX);
    repeat (3) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      run_hl(VEC[i][0], VEC[i][1], VEC[i][2], n);
      chk(n == VEC[i][3], tag_of(VEC[i][2], VEC[i][3]), n, VEC[i][3]);
      // R7 held value
      chk(dt_count == VEC[i][3], "R7 dt_count", dt_count, VEC[i][3]);
      repeat (3) @(negedge clk);
      // R8 copied gap
      run_lh(1'b0, n);
      chk(n == VEC[i][3], "R8 copied gap", n, VEC[i][3]);
      repeat (3) @(negedge clk);
    end

    // R8 flag activity during the low-to-high gap is ignored
    run_hl(2, 6, 1, n);
    chk(n == 8, "R3 gap before wiggle", n, 8);
    repeat (3) @(negedge clk);
    run_lh(1'b1, n);
    chk(n == 8, "R8 gap with flag toggling", n, 8);
    chk(dt_count == 8, "R8 dt_count unchanged", dt_count, 8);
    repeat (3) @(negedge clk);

    // R9 reset in the middle of a gap
    phase_cmd = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(!hs_en && !ls_en, "R9 enables after reset", {hs_en, ls_en}, 0);
    chk(dt_count == DT_MAX, "R9 dt_count after reset", dt_count, DT_MAX);
    rst = 1'b0;

    // R1 over the whole run
    chk(overlap == 0, "R1 overlapping enables", overlap, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule